// File: doc/BRIEF.md
# Row/Column Multiplexed Byte-Flash Bus Front End

This block sits between an 8-bit parallel flash bus and the internal array and command logic of a byte-wide flash. The address does not arrive whole. It comes in two halves over one set of 11 address pins, and a row/column select pin says which half is present. The block captures the row half when the select pin falls and the column half when it rises. It then joins the 11 row bits to the low 8 column bits, which gives a 19-bit byte address.

With the bus in read condition, the block drives the data pins with a byte from one of three places: the array, the identifier (signature) source or the status source. The command logic picks the place through `src_i`. With the bus in write condition, a rising write enable hands the byte on the data pins and the current address to the command register port as a one-cycle strobe.

An active-low interface reset pin does four things:
- It deselects the bus.
- It releases the data pins.
- It freezes address capture and command writes.
- If a program or erase is running, it asks for that operation to be aborted, and it signals completion after a configurable recovery time.

In this mode every block reads as unprotected, and protect requests have no effect. All bus pins are assumed to be synchronous to `clk_i`. Edges are detected on consecutive samples taken at the clock edge.

Top module: `mux_flash_if`

## Requirements
- R1: When a clock edge samples `rc_sel_i` low after a high sample, `addr_i` is captured as the row half. When a clock edge samples it high after a low sample, `addr_i[7:0]` is captured as the column half. The captured value is visible after that same edge.
- R2: `arr_addr_o` equals {row[10:0], column[7:0]}, which is 19 bits with the row half in the upper bits.
- R3: `data_oe_o` is 1 exactly when `rp_ni`=1, `we_ni`=1 and `oe_ni`=0. In that state `data_o` is the array byte when `src_i`=0, the signature byte when `src_i`=1, and the status byte when `src_i` is 2 or 3.
- R4: While `oe_ni`=1, `data_oe_o` is 0.
- R5: While `rp_ni`=0, `data_oe_o` is 0, the address halves are not captured and no command write is issued.
- R6: A clock edge can sample `we_ni` high after a low sample while `oe_ni`=1 and `rp_ni`=1. In that case `cmd_wr_o` is 1 for exactly the one cycle that follows that edge. `cmd_data_o` then holds `data_i` as sampled at that edge, and `cmd_addr_o` holds the byte address.
- R7: No command write occurs while `we_ni` stays low or stays high, or when `oe_ni`=0 at the rising edge of `we_ni`.
- R8: When a clock edge samples `rp_ni` low after a high sample while `busy_i`=1, `abort_o` is 1 for the one cycle that follows that edge. If `busy_i`=0, no abort is raised.
- R9: `abort_done_o` pulses for one cycle exactly RECOVER_CYC cycles after `abort_o`.
- R10: `lock_status_o` is all zeros whatever the value of `lock_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rp_ni | input | 1 | Interface reset pin, active low |
| addr_i | input | 11 | Shared row/column address pins |
| rc_sel_i | input | 1 | Row/column select |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_i | input | 8 | Data pins, inbound |
| data_o | output | 8 | Data pins, outbound |
| data_oe_o | output | 1 | Data pin driver enable |
| src_i | input | 2 | Read source select |
| arr_addr_o | output | 19 | Byte address to the array |
| arr_data_i | input | 8 | Array read byte |
| sig_data_i | input | 8 | Signature byte |
| stat_data_i | input | 8 | Status byte |
| cmd_wr_o | output | 1 | Command write strobe |
| cmd_addr_o | output | 19 | Command write address |
| cmd_data_o | output | 8 | Command write data |
| busy_i | input | 1 | Program or erase in progress |
| abort_o | output | 1 | Abort request pulse |
| abort_done_o | output | 1 | Abort recovery complete pulse |
| lock_req_i | input | 8 | Block protect requests (ignored) |
| lock_status_o | output | 8 | Block protect status |

## Verification
The hardest case to reach is an interface reset that lands while a program or erase is running. It must raise the abort and must then wait the full recovery count before it reports completion. The stimulus holds `busy_i` high and drops `rp_ni`. During the recovery window it also tries address captures and command writes, and it counts cycles up to the completion pulse. A second reset with `busy_i` low confirms that no abort follows. Random reads and writes are mixed in, with write data changing through the whole low phase of write enable. This shows that only the byte present at the rising edge is taken.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_SIG   = 2'd1,
    SRC_STAT  = 2'd2,
    SRC_STATX = 2'd3
  } rd_src_e;
endpackage

// File: rtl/mfi_addr_latch.sv
module mfi_addr_latch #(
  parameter int ROW_W    = 11,
  parameter int COL_KEEP = 8,
  localparam int ADDR_W  = ROW_W + COL_KEEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rp_ni,
  input  logic              rc_sel_i,
  input  logic [ROW_W-1:0]  addr_i,
  output logic [ADDR_W-1:0] byte_addr_o
);
  logic                rc_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_KEEP-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q  <= 1'b1;
      row_q <= '0;
      col_q <= '0;
    end else begin
      rc_q <= rc_sel_i;
      if (rp_ni) begin
        if (rc_q && !rc_sel_i) row_q <= addr_i;
        if (!rc_q && rc_sel_i) col_q <= addr_i[COL_KEEP-1:0];
      end
    end
  end

  assign byte_addr_o = {row_q, col_q};

  assert_addr_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_ni |=> $stable(byte_addr_o));
  assert_row_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_sel_i == rc_q) |=> $stable(byte_addr_o));
endmodule

// File: rtl/mfi_cmd_wr.sv
module mfi_cmd_wr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rp_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic we_q;
  logic take;

  // rising edge of the active-low strobe ends the write
  assign take = we_ni && !we_q && oe_ni && rp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      wr_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_q <= we_ni;
      wr_o <= take;
      if (take) begin
        waddr_o <= addr_i;
        wdata_o <= data_i;
      end
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  assert_no_wr_oe_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(oe_ni) && $past(rp_ni));
endmodule

// File: rtl/mfi_abort_timer.sv
module mfi_abort_timer #(
  parameter int RECOVER_CYC = 20,
  localparam int CNT_W      = $clog2(RECOVER_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rp_ni,
  input  logic busy_i,
  output logic abort_o,
  output logic done_o
);
  logic             rp_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = rp_q && !rp_ni && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q     <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      abort_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      rp_q    <= rp_ni;
      abort_o <= hit;
      done_o  <= 1'b0;
      if (hit) begin
        cnt_q    <= CNT_W'(RECOVER_CYC);
        active_q <= 1'b1;
      end else if (active_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          done_o   <= 1'b1;
          active_q <= 1'b0;
        end
      end
    end
  end

  // independent gap counter for the recovery window
  logic [CNT_W:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (abort_o) gap_q <= (CNT_W+1)'(1);
    else if (gap_q != '0 && gap_q <= (CNT_W+1)'(RECOVER_CYC)) gap_q <= gap_q + 1'b1;
  end

  assert_recover_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> gap_q == (CNT_W+1)'(RECOVER_CYC));
  assert_abort_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(busy_i) && !$past(rp_ni));
endmodule

// File: rtl/mux_flash_if.sv
module mux_flash_if #(
  parameter int ROW_W       = 11,
  parameter int COL_KEEP    = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_BLK     = 8,
  parameter int RECOVER_CYC = 20,
  localparam int ADDR_W     = ROW_W + COL_KEEP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rp_ni,
  input  logic [ROW_W-1:0]   addr_i,
  input  logic               rc_sel_i,
  input  logic               oe_ni,
  input  logic               we_ni,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               data_oe_o,
  input  logic [1:0]         src_i,
  output logic [ADDR_W-1:0]  arr_addr_o,
  input  logic [DATA_W-1:0]  arr_data_i,
  input  logic [DATA_W-1:0]  sig_data_i,
  input  logic [DATA_W-1:0]  stat_data_i,
  output logic               cmd_wr_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [DATA_W-1:0]  cmd_data_o,
  input  logic               busy_i,
  output logic               abort_o,
  output logic               abort_done_o,
  input  logic [NUM_BLK-1:0] lock_req_i,
  output logic [NUM_BLK-1:0] lock_status_o
);
  import mfi_pkg::*;

  logic [ADDR_W-1:0] byte_addr;
  logic [DATA_W-1:0] rd_byte;
  rd_src_e           src;

  mfi_addr_latch #(.ROW_W(ROW_W), .COL_KEEP(COL_KEEP)) u_latch (
    .clk_i, .rst_ni, .rp_ni, .rc_sel_i, .addr_i,
    .byte_addr_o (byte_addr)
  );

  mfi_cmd_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .rp_ni, .oe_ni, .we_ni, .data_i,
    .addr_i  (byte_addr),
    .wr_o    (cmd_wr_o),
    .waddr_o (cmd_addr_o),
    .wdata_o (cmd_data_o)
  );

  mfi_abort_timer #(.RECOVER_CYC(RECOVER_CYC)) u_abort (
    .clk_i, .rst_ni, .rp_ni, .busy_i,
    .abort_o (abort_o),
    .done_o  (abort_done_o)
  );

  assign arr_addr_o = byte_addr;
  assign src        = rd_src_e'(src_i);

  always_comb begin
    unique case (src)
      SRC_ARRAY: rd_byte = arr_data_i;
      SRC_SIG:   rd_byte = sig_data_i;
      default:   rd_byte = stat_data_i;
    endcase
  end

  assign data_oe_o = rp_ni && we_ni && !oe_ni;
  assign data_o    = data_oe_o ? rd_byte : '0;

  // protection is not reachable in this mode
  logic unused_lock;
  assign unused_lock   = ^lock_req_i;
  assign lock_status_o = '0;

  assert_bus_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |-> !$past(data_oe_o));
endmodule

// File: tb/mux_flash_if_tb_top.sv
module mux_flash_if_tb_top;
  localparam int RCV = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rp_ni = 1'b1;
  logic [10:0] addr_i = '0;
  logic        rc_sel_i = 1'b1;
  logic        oe_ni = 1'b1;
  logic        we_ni = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o;
  logic [1:0]  src_i = '0;
  logic [18:0] arr_addr_o;
  logic [7:0]  arr_data_i;
  logic [7:0]  sig_data_i = 8'h20;
  logic [7:0]  stat_data_i = 8'h80;
  logic        cmd_wr_o;
  logic [18:0] cmd_addr_o;
  logic [7:0]  cmd_data_o;
  logic        busy_i = 1'b0;
  logic        abort_o;
  logic        abort_done_o;
  logic [7:0]  lock_req_i = '0;
  logic [7:0]  lock_status_o;

  int checks = 0;
  int fails  = 0;
  logic [10:0] cur_row = '0;
  logic [7:0]  cur_col = '0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr_fn(logic [18:0] a);
    return a[7:0] ^ a[18:11] ^ {5'b0, a[10:8]} ^ 8'h5A;
  endfunction

  assign arr_data_i = arr_fn(arr_addr_o);

  mux_flash_if #(.RECOVER_CYC(RCV)) dut_i (
    .clk_i(clk), .rst_ni, .rp_ni, .addr_i, .rc_sel_i, .oe_ni, .we_ni,
    .data_i, .data_o, .data_oe_o, .src_i, .arr_addr_o, .arr_data_i,
    .sig_data_i, .stat_data_i, .cmd_wr_o, .cmd_addr_o, .cmd_data_o,
    .busy_i, .abort_o, .abort_done_o, .lock_req_i, .lock_status_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] s, logic [18:0] a);
    case (s)
      2'd0:    return arr_fn(a);
      2'd1:    return sig_data_i;
      default: return stat_data_i;
    endcase
  endfunction

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic latch_addr(input logic [10:0] r, input logic [10:0] c, input bit upd);
    @(negedge clk); addr_i = r; rc_sel_i = 1'b0;
    edge_sample();
    @(negedge clk); addr_i = c; rc_sel_i = 1'b1;
    edge_sample();
    if (upd) begin cur_row = r; cur_col = c[7:0]; end
  endtask

  task automatic do_read(input logic [1:0] s);
    logic [18:0] ea;
    ea = {cur_row, cur_col};
    @(negedge clk); src_i = s; oe_ni = 1'b0; #1;
    chk(arr_addr_o == ea, "R2 addr", 32'(arr_addr_o), 32'(ea));
    chk(data_oe_o == 1'b1, "R3 oe", 32'(data_oe_o), 1);
    chk(data_o == exp_rd(s, ea), "R3 data", 32'(data_o), 32'(exp_rd(s, ea)));
    @(negedge clk); oe_ni = 1'b1; #1;
    chk(data_oe_o == 1'b0, "R4 oe high", 32'(data_oe_o), 0);
  endtask

  task automatic do_write(input logic [7:0] d, input int low_cyc, input bit oe_low, input bit expect_wr);
    @(negedge clk); we_ni = 1'b0; oe_ni = oe_low ? 1'b0 : 1'b1;
    for (int i = 0; i < low_cyc; i++) begin
      data_i = 8'($urandom);
      edge_sample();
      chk(cmd_wr_o == 1'b0, "R7 we low", 32'(cmd_wr_o), 0);
      @(negedge clk);
    end
    data_i = d; we_ni = 1'b1;
    edge_sample();
    chk(cmd_wr_o == expect_wr, "R6 strobe", 32'(cmd_wr_o), 32'(expect_wr));
    if (expect_wr) begin
      chk(cmd_data_o == d, "R6 data", 32'(cmd_data_o), 32'(d));
      chk(cmd_addr_o == {cur_row, cur_col}, "R6 addr", 32'(cmd_addr_o), 32'({cur_row, cur_col}));
    end
    @(negedge clk); data_i = ~d; oe_ni = 1'b1;
    edge_sample();
    chk(cmd_wr_o == 1'b0, "R7 we high", 32'(cmd_wr_o), 0);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog got=0 exp=1");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(data_oe_o == 0 && cmd_wr_o == 0 && abort_o == 0 && arr_addr_o == 0,
        "R5 reset state", {data_oe_o, cmd_wr_o, abort_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    edge_sample();

    // R1 directed: row on fall, column on rise
    @(negedge clk); addr_i = 11'h5A3; rc_sel_i = 1'b0;
    edge_sample();
    chk(arr_addr_o[18:8] == 11'h5A3, "R1 row", 32'(arr_addr_o[18:8]), 32'h5A3);
    @(negedge clk); addr_i = 11'h7C6;
    edge_sample();
    chk(arr_addr_o[18:8] == 11'h5A3, "R1 row hold", 32'(arr_addr_o[18:8]), 32'h5A3);
    @(negedge clk); rc_sel_i = 1'b1;
    edge_sample();
    chk(arr_addr_o == {11'h5A3, 8'hC6}, "R1 col R2", 32'(arr_addr_o), 32'({11'h5A3, 8'hC6}));
    cur_row = 11'h5A3; cur_col = 8'hC6;

    // boundary addresses
    latch_addr(11'h7FF, 11'h7FF, 1'b1); do_read(2'd0);
    latch_addr(11'h000, 11'h000, 1'b1); do_read(2'd3);

    // R10 protect ignored
    @(negedge clk); lock_req_i = 8'hFF;
    edge_sample();
    chk(lock_status_o == 8'h00, "R10 lock", 32'(lock_status_o), 0);
    lock_req_i = '0;

    // R3 with we low: no drive
    @(negedge clk); oe_ni = 1'b0; we_ni = 1'b0; #1;
    chk(data_oe_o == 1'b0, "R3 we low", 32'(data_oe_o), 0);
    @(negedge clk); we_ni = 1'b1; oe_ni = 1'b1;
    edge_sample();

    // R7: write with oe low is refused
    do_write(8'h3C, 2, 1'b1, 1'b0);

    // random reads and writes
    for (int n = 0; n < 60; n++) begin
      latch_addr(11'($urandom), 11'($urandom), 1'b1);
      do_read(2'($urandom));
      do_write(8'($urandom), 1 + ($urandom % 4), 1'b0, 1'b1);
    end

    // R5/R8: reset pin during busy
    latch_addr(11'h123, 11'h045, 1'b1);
    @(negedge clk); busy_i = 1'b1; rp_ni = 1'b0; oe_ni = 1'b0;
    edge_sample();
    chk(abort_o == 1'b1, "R8 abort", 32'(abort_o), 1);
    chk(data_oe_o == 1'b0, "R5 rp oe", 32'(data_oe_o), 0);
    begin
      int cyc = 0;
      bit seen = 0;
      @(negedge clk); oe_ni = 1'b1;
      edge_sample(); cyc++;
      chk(abort_o == 1'b0, "R8 one pulse", 32'(abort_o), 0);
      latch_addr(11'h6AA, 11'h0BB, 1'b0); cyc += 2;
      chk(arr_addr_o == {11'h123, 8'h45}, "R5 no latch", 32'(arr_addr_o), 32'({11'h123, 8'h45}));
      do_write(8'h99, 1, 1'b0, 1'b0); cyc += 3;
      while (cyc < RCV + 5) begin
        if (abort_done_o) begin
          chk(cyc == RCV && !seen, "R9 delay", 32'(cyc), 32'(RCV));
          seen = 1;
        end
        edge_sample(); cyc++;
      end
      chk(seen, "R9 done seen", 32'(seen), 1);
    end
    @(negedge clk); rp_ni = 1'b1; busy_i = 1'b0;
    edge_sample();

    // R8: reset without busy gives no abort
    @(negedge clk); rp_ni = 1'b0;
    edge_sample();
    chk(abort_o == 1'b0, "R8 no busy", 32'(abort_o), 0);
    repeat (RCV + 2) begin
      edge_sample();
      chk(abort_done_o == 1'b0, "R9 no done", 32'(abort_done_o), 0);
    end
    @(negedge clk); rp_ni = 1'b1;
    edge_sample();
    do_read(2'd1);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule